// File: doc/BRIEF.md
# Tamper Detection and Event Logger

This block watches four tamper pins, both while the device runs and while it hibernates. Each pin passes through a synchronizer. The pin has its own enable and its own active-level select, plus an optional digital filter that turns away short pulses. When a pin that is enabled becomes active, the block treats this as one tamper event. It writes the event into a four-slot log, together with the RTC seconds value of the moment it is logged.

Each event then triggers the response set in the control word. The choices are a sticky interrupt, a sticky request to wake from hibernation, and an erase that writes zero over a battery-backed store of sixteen 32-bit words. Software works through a small register port with combinational read data. It writes the control word, reads the status and the log, and clears the log and the flags. A separate word port reads and writes the battery-backed store.

Top module: `tamper_guard`

## Requirements
- R1: Control word (address 0) holds per-pin enable in bits 3:0 and active level in bits 7:4 (1 = active high, 0 = active low). A disabled pin, or a pin driven to its inactive level, produces no event.
- R2: Filter enable sits in control bits 11:8. With the filter off, a one-clock active pulse is logged. With the filter on, the pin must hold its active level for 4 consecutive clocks: a 3-clock pulse is rejected and a 4-clock pulse is logged.
- R3: An input held active produces exactly one event until it returns to the inactive level.
- R4: Log slot k (k = 0..3) gives its stamp at address 2+k and its tag at address 6+k. The tag holds bit 2 = valid and bits 1:0 = pin index. Slots fill in order 0, 1, 2, 3. The stamp is the RTC seconds value in the clock in which the event is written.
- R5: Events from several pins in the same clock are logged one per clock, lowest pin index first.
- R6: Once all four slots are valid, further events leave the log unchanged and set the sticky overflow flag (status bit 4).
- R7: Control bit 16 makes each event set the `irq` output, and control bit 17 makes it set `wake_req`. Both are sticky and show in status bits 7 and 8.
- R8: With control bit 18 set, an event starts an erase that writes zero to all sixteen words, one per clock. Status bit 5 shows the erase as busy, and status bit 6 sets when it finishes. Word-port writes are ignored while the erase is busy.
- R9: Writing address 1 with data bit 0 set clears the log, overflow, done, `irq` and `wake_req`. While an erase is busy this write has no effect.
- R10: After reset the control word, status, `irq` and `wake_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_in | input | 4 | Raw tamper pins |
| rtc_sec | input | 32 | RTC seconds value used as stamp |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_wr | input | 1 | Battery-backed store write strobe |
| mem_addr | input | 4 | Store word address |
| mem_wdata | input | 32 | Store write data |
| mem_rdata | output | 32 | Store read data (combinational) |
| irq | output | 1 | Sticky tamper interrupt |
| wake_req | output | 1 | Sticky wake-from-hibernate request |

## Verification
The detection path is driven with pulses of width one to six clocks. These go to random pins under random enable, level and filter settings, so that the 3-versus-4 clock filter threshold and the enable and level masks are each separated from plain pass-through. Directed patterns add a long hold, which separates edge detection from level detection. They also add two pins asserted in the same clock, which exposes the slot order, and five pulses in a row, which fill the log and then overflow it. The erase pattern issues a clear and a store write in the middle of an erase, which shows whether either can disturb a busy erase.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int TP_INPUTS    = 4;
  localparam int TP_LOG_DEPTH = 4;
  localparam int TP_MEM_WORDS = 16;
  localparam int TP_DATA_W    = 32;
  localparam int TP_IDX_W     = $clog2(TP_INPUTS);

  // control word field positions
  localparam int CTRL_EN_LSB    = 0;
  localparam int CTRL_LVL_LSB   = 4;
  localparam int CTRL_FILT_LSB  = 8;
  localparam int CTRL_IRQ_BIT   = 16;
  localparam int CTRL_WAKE_BIT  = 17;
  localparam int CTRL_ERASE_BIT = 18;

  // register addresses
  localparam int A_CTRL   = 0;
  localparam int A_STAT   = 1;
  localparam int A_STAMP0 = 2;

  typedef struct packed {
    logic                 valid;
    logic [TP_IDX_W-1:0]  idx;
    logic [TP_DATA_W-1:0] stamp;
  } log_entry_t;

  // lowest set bit index, 0 when none set
  function automatic logic [TP_IDX_W-1:0] first_set(input logic [TP_INPUTS-1:0] v);
    logic [TP_IDX_W-1:0] r;
    r = '0;
    for (int k = TP_INPUTS - 1; k >= 0; k--) begin
      if (v[k]) r = TP_IDX_W'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/tamper_filter.sv
module tamper_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic level,
  input  logic filt_on,
  input  logic enable,
  output logic act,
  output logic evt
);
  localparam int CW = $clog2(HOLD + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   qual;
  logic                   qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end

  assign act = level ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];

  // run length of consecutive active samples, saturating at HOLD
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (!act)              run_q <= '0;
    else if (run_q != CW'(HOLD)) run_q <= run_q + 1'b1;
  end

  assign qual = enable & (filt_on ? (run_q == CW'(HOLD)) : act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_q <= 1'b0;
    else        qual_q <= qual;
  end

  assign evt = qual & ~qual_q;
endmodule

// File: rtl/tamper_log.sv
module tamper_log
  import tamper_pkg::*;
#(
  parameter int DEPTH = TP_LOG_DEPTH,
  parameter int NIN   = TP_INPUTS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NIN-1:0]           evt,
  input  logic [TP_DATA_W-1:0]     stamp,
  input  logic                     clr,
  output log_entry_t [DEPTH-1:0]   entries,
  output logic [DEPTH-1:0]         valid,
  output logic                     full,
  output logic                     ovf,
  output logic                     pop,
  output logic [TP_IDX_W-1:0]      pop_idx
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [NIN-1:0] pend_q;
  logic [NIN-1:0] pop_mask;
  logic [CW-1:0]  fill;

  for (genvar g = 0; g < DEPTH; g++) begin : g_valid
    assign valid[g] = entries[g].valid;
  end

  always_comb begin
    fill = '0;
    for (int k = 0; k < DEPTH; k++) fill = fill + CW'(valid[k]);
  end

  assign full     = (fill == CW'(DEPTH));
  assign pop      = |pend_q;
  assign pop_idx  = first_set(pend_q);
  assign pop_mask = pop ? (NIN'(1) << pop_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      entries <= '0;
      ovf     <= 1'b0;
    end else if (clr) begin
      pend_q  <= '0;
      entries <= '0;
      ovf     <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~pop_mask) | evt;
      if (pop) begin
        if (full) ovf <= 1'b1;
        else      entries[fill[PW-1:0]] <= '{valid: 1'b1, idx: pop_idx, stamp: stamp};
      end
    end
  end
endmodule

// File: rtl/tamper_bkmem.sv
module tamper_bkmem #(
  parameter int WORDS = 16,
  parameter int DW    = 32,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clr_done,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_wdata,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done
);
  logic [DW-1:0] mem [WORDS];
  logic [AW-1:0] ptr_q;

  // storage keeps its contents across reset
  always_ff @(posedge clk) begin
    if (busy)       mem[ptr_q]   <= '0;
    else if (sw_we) mem[sw_addr] <= sw_wdata;
  end

  assign rd_data = mem[sw_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      ptr_q <= '0;
    end else if (busy) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == AW'(WORDS - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else if (start) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      ptr_q <= '0;
    end else if (clr_done) begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tamper_pkg::*;
#(
  parameter int NIN         = TP_INPUTS,
  parameter int DEPTH       = TP_LOG_DEPTH,
  parameter int WORDS       = TP_MEM_WORDS,
  parameter int DW          = TP_DATA_W,
  parameter int AW          = 4,
  parameter int MAW         = $clog2(WORDS),
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIN-1:0] tamper_in,
  input  logic [DW-1:0]  rtc_sec,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           mem_wr,
  input  logic [MAW-1:0] mem_addr,
  input  logic [DW-1:0]  mem_wdata,
  output logic [DW-1:0]  mem_rdata,
  output logic           irq,
  output logic           wake_req
);
  localparam int TAG0 = A_STAMP0 + DEPTH;

  logic [DW-1:0]          ctrl_q;
  logic [NIN-1:0]         en, lvl, fen;
  logic [NIN-1:0]         act, evt;
  log_entry_t [DEPTH-1:0] entries;
  logic [DEPTH-1:0]       log_valid;
  logic                   log_full, ovf, pop;
  logic [TP_IDX_W-1:0]    pop_idx;
  logic                   clr_cmd, clr_req;
  logic                   erase_busy, erase_done, erase_go;
  logic [DW-1:0]          status;

  assign en  = ctrl_q[CTRL_EN_LSB   +: NIN];
  assign lvl = ctrl_q[CTRL_LVL_LSB  +: NIN];
  assign fen = ctrl_q[CTRL_FILT_LSB +: NIN];

  assign clr_cmd  = reg_wr && (reg_addr == AW'(A_STAT)) && reg_wdata[0];
  assign clr_req  = clr_cmd && !erase_busy;
  assign erase_go = pop && ctrl_q[CTRL_ERASE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_wr && reg_addr == AW'(A_CTRL)) ctrl_q <= reg_wdata;
  end

  for (genvar g = 0; g < NIN; g++) begin : g_pin
    tamper_filter #(.SYNC_STAGES(SYNC_STAGES), .HOLD(HOLD)) u_filt (
      .clk(clk), .rst_n(rst_n), .pin(tamper_in[g]), .level(lvl[g]),
      .filt_on(fen[g]), .enable(en[g]), .act(act[g]), .evt(evt[g])
    );
  end

  tamper_log #(.DEPTH(DEPTH), .NIN(NIN)) u_log (
    .clk(clk), .rst_n(rst_n), .evt(evt), .stamp(rtc_sec), .clr(clr_req),
    .entries(entries), .valid(log_valid), .full(log_full), .ovf(ovf),
    .pop(pop), .pop_idx(pop_idx)
  );

  tamper_bkmem #(.WORDS(WORDS), .DW(DW), .AW(MAW)) u_mem (
    .clk(clk), .rst_n(rst_n), .start(erase_go), .clr_done(clr_req),
    .sw_we(mem_wr), .sw_addr(mem_addr), .sw_wdata(mem_wdata),
    .rd_data(mem_rdata), .busy(erase_busy), .done(erase_done)
  );

  // sticky responses: a new event wins over a clear in the same clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      if (pop && ctrl_q[CTRL_IRQ_BIT])       irq <= 1'b1;
      else if (clr_req)                      irq <= 1'b0;
      if (pop && ctrl_q[CTRL_WAKE_BIT])      wake_req <= 1'b1;
      else if (clr_req)                      wake_req <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[DEPTH-1:0] = log_valid;
    status[DEPTH]     = ovf;
    status[DEPTH+1]   = erase_busy;
    status[DEPTH+2]   = erase_done;
    status[DEPTH+3]   = irq;
    status[DEPTH+4]   = wake_req;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CTRL)) reg_rdata = ctrl_q;
    if (reg_addr == AW'(A_STAT)) reg_rdata = status;
    for (int k = 0; k < DEPTH; k++) begin
      if (reg_addr == AW'(A_STAMP0 + k)) reg_rdata = entries[k].stamp;
      if (reg_addr == AW'(TAG0 + k))     reg_rdata = DW'({entries[k].valid, entries[k].idx});
    end
  end
endmodule

// File: rtl/tamper_guard_sva.sv
module tamper_guard_sva #(
  parameter int NIN   = 4,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NIN-1:0]   fen,
  input logic [NIN-1:0]   act,
  input logic [NIN-1:0]   evt,
  input logic             pop,
  input logic             log_full,
  input logic [DEPTH-1:0] log_valid,
  input logic             ovf,
  input logic             clr_cmd,
  input logic             clr_req,
  input logic             erase_busy,
  input logic             erase_done,
  input logic             irq
);
  for (genvar g = 0; g < NIN; g++) begin : g_hold
    AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[g] && fen[g]) |-> ($past(act[g]) && $past(act[g], 2) && $past(act[g], 3) && $past(act[g], 4))); // R2
  end

  AST_LOG_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !log_full && !clr_req) |=> ($countones(log_valid) == $countones($past(log_valid)) + 1)); // R4

  AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && log_full && !clr_req) |=> ($stable(log_valid) && ovf)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_req) |=> ovf); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> irq); // R7

  AST_ERASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_busy) |-> erase_done); // R8

  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && erase_busy && ovf) |=> ovf); // R9
endmodule

bind tamper_guard tamper_guard_sva #(.NIN(NIN), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .fen(fen), .act(act), .evt(evt), .pop(pop),
  .log_full(log_full), .log_valid(log_valid), .ovf(ovf), .clr_cmd(clr_cmd),
  .clr_req(clr_req), .erase_busy(erase_busy), .erase_done(erase_done), .irq(irq)
);

// File: tb/test_tamper_guard.sv
`timescale 1ns/1ps
module test_tamper_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tamper_in = 4'h0;
  logic [31:0] rtc_sec = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_wr = 1'b0;
  logic [3:0]  mem_addr = '0;
  logic [31:0] mem_wdata = '0;
  logic [31:0] mem_rdata;
  logic        irq, wake_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [3:0] lvl_cur = 4'hF;

  always #2 clk = ~clk;

  tamper_guard i_tamper_guard (
    .clk(clk), .rst_n(rst_n), .tamper_in(tamper_in), .rtc_sec(rtc_sec),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq(irq), .wake_req(wake_req)
  );

  function automatic logic [31:0] ctrl_word(input logic [3:0] en, lvl, filt,
                                            input bit ri, rw, re);
    return {13'd0, re, rw, ri, 4'd0, filt, lvl, en};
  endfunction

  function automatic logic [31:0] stat_word(input int nvalid, input bit ovf, busy, done, ir, wk);
    logic [31:0] s;
    s = (32'd1 << nvalid) - 32'd1;
    s[4] = ovf; s[5] = busy; s[6] = done; s[7] = ir; s[8] = wk;
    return s;
  endfunction

  function automatic logic [31:0] tag_word(input int idx);
    return 32'd4 | 32'(idx);
  endfunction

  function automatic bit accepted(input bit en, filt, input int w);
    return en && (!filt || w >= 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic mwr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_wr = 1'b0;
  endtask

  task automatic mrd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    mem_addr = a;
    #1 v = mem_rdata;
  endtask

  task automatic arm(input logic [3:0] en, lvl, filt, input bit ri, rw, re);
    wr(4'd0, ctrl_word(4'h0, lvl, filt, ri, rw, re));
    @(negedge clk);
    lvl_cur = lvl;
    tamper_in = ~lvl;
    repeat (8) @(negedge clk);
    wr(4'd1, 32'd1);
    wr(4'd0, ctrl_word(en, lvl, filt, ri, rw, re));
  endtask

  task automatic pulse(input int i, input int w);
    @(negedge clk);
    tamper_in[i] = lvl_cur[i];
    repeat (w) @(negedge clk);
    tamper_in[i] = ~lvl_cur[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit seen;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(4'd0, v); chk("R10 ctrl", v, 32'd0);
    rd(4'd1, v); chk("R10 status", v, 32'd0);
    chk("R10 irq", 32'(irq), 32'd0);
    chk("R10 wake", 32'(wake_req), 32'd0);

    // R2 R4 R7 single unfiltered one-clock pulse, active high
    arm(4'hF, 4'hF, 4'h0, 1, 0, 0);
    rtc_sec = 32'h0000_1234;
    pulse(0, 1);
    repeat (12) @(negedge clk);
    rd(4'd1, v); chk("R2 one-clock pulse logged", v, stat_word(1, 0, 0, 0, 1, 0));
    rd(4'd6, v); chk("R4 tag slot0", v, tag_word(0));
    rd(4'd2, v); chk("R4 stamp slot0", v, 32'h0000_1234);
    chk("R7 irq set", 32'(irq), 32'd1);
    chk("R7 wake clear", 32'(wake_req), 32'd0);

    // R3 long hold produces one event
    arm(4'hF, 4'hF, 4'h0, 1, 0, 0);
    pulse(2, 20);
    repeat (12) @(negedge clk);
    rd(4'd1, v); chk("R3 held pin single event", v, stat_word(1, 0, 0, 0, 1, 0));
    rd(4'd6, v); chk("R3 tag", v, tag_word(2));

    // R5 simultaneous events
    arm(4'hF, 4'hF, 4'h0, 1, 0, 0);
    @(negedge clk);
    tamper_in[3] = 1'b1; tamper_in[1] = 1'b1;
    repeat (2) @(negedge clk);
    tamper_in[3] = 1'b0; tamper_in[1] = 1'b0;
    repeat (12) @(negedge clk);
    rd(4'd1, v); chk("R5 two logged", v, stat_word(2, 0, 0, 0, 1, 0));
    rd(4'd6, v); chk("R5 lower index first", v, tag_word(1));
    rd(4'd7, v); chk("R5 higher index second", v, tag_word(3));

    // R6 overflow after four entries
    arm(4'hF, 4'hF, 4'h0, 1, 0, 0);
    for (int p = 0; p < 5; p++) begin
      rtc_sec = 32'd100 + 32'(p);
      pulse(0, 1);
      repeat (12) @(negedge clk);
    end
    rd(4'd1, v); chk("R6 full and overflow", v, stat_word(4, 1, 0, 0, 1, 0));
    rd(4'd5, v); chk("R6 slot3 stamp from fourth event", v, 32'd103);
    rd(4'd2, v); chk("R6 slot0 untouched", v, 32'd100);
    rd(4'd9, v); chk("R4 slot3 tag", v, tag_word(0));

    // R9 clear outside erase
    wr(4'd1, 32'd1);
    rd(4'd1, v); chk("R9 clear empties", v, 32'd0);
    chk("R9 irq cleared", 32'(irq), 32'd0);

    // R1 disabled pin ignored
    arm(4'h1, 4'hF, 4'h0, 1, 0, 0);
    pulse(1, 3);
    repeat (12) @(negedge clk);
    rd(4'd1, v); chk("R1 disabled pin ignored", v, 32'd0);
    chk("R1 no irq from disabled pin", 32'(irq), 32'd0);

    // R1 active low: high drive ignored, low pulse logged
    arm(4'hF, 4'h0, 4'h0, 1, 0, 0);
    @(negedge clk); tamper_in[2] = 1'b1;
    repeat (12) @(negedge clk);
    rd(4'd1, v); chk("R1 inactive level ignored", v, 32'd0);
    pulse(2, 2);
    repeat (12) @(negedge clk);
    rd(4'd1, v); chk("R1 active-low logged", v, stat_word(1, 0, 0, 0, 1, 0));

    // R2 filter threshold
    arm(4'hF, 4'hF, 4'h1, 1, 0, 0);
    pulse(0, 3);
    repeat (12) @(negedge clk);
    rd(4'd1, v); chk("R2 filtered 3-clock rejected", v, 32'd0);
    pulse(0, 4);
    repeat (12) @(negedge clk);
    rd(4'd1, v); chk("R2 filtered 4-clock logged", v, stat_word(1, 0, 0, 0, 1, 0));

    // R7 wake only
    arm(4'hF, 4'hF, 4'h0, 0, 1, 0);
    pulse(3, 1);
    repeat (12) @(negedge clk);
    chk("R7 wake set", 32'(wake_req), 32'd1);
    chk("R7 irq stays low", 32'(irq), 32'd0);
    rd(4'd1, v); chk("R7 status wake bit", v, stat_word(1, 0, 0, 0, 0, 1));

    // R8 R9 erase
    for (int k = 0; k < 16; k++) mwr(4'(k), 32'hA5A5_0000 + 32'(k));
    mrd(4'd7, v); chk("R8 store write", v, 32'hA5A5_0007);
    arm(4'hF, 4'hF, 4'h0, 1, 0, 1);
    pulse(1, 1);
    seen = 1'b0;
    for (int t = 0; t < 20 && !seen; t++) begin
      rd(4'd1, v);
      if (v[5]) seen = 1'b1;
    end
    chk("R8 erase busy seen", 32'(seen), 32'd1);
    wr(4'd1, 32'd1);
    rd(4'd1, v); chk("R9 clear ignored while busy", 32'(v[3:0]), 32'h1);
    repeat (4) @(negedge clk);
    mwr(4'd0, 32'hDEAD_BEEF);
    repeat (30) @(negedge clk);
    rd(4'd1, v); chk("R8 erase done", v, stat_word(1, 0, 0, 1, 1, 0));
    for (int k = 0; k < 16; k++) begin
      mrd(4'(k), v); chk("R8 word zeroed", v, 32'd0);
    end
    wr(4'd1, 32'd1);
    rd(4'd1, v); chk("R9 clear after erase", v, 32'd0);

    // random mix, R1 R2 R4
    for (int n = 0; n < 30; n++) begin
      logic [3:0] en, lv, fl;
      int i, w;
      bit exp;
      logic [31:0] ts;
      en = 4'($urandom); lv = 4'($urandom); fl = 4'($urandom);
      i = int'($urandom % 4); w = 1 + int'($urandom % 6);
      ts = $urandom;
      arm(en, lv, fl, 1, 0, 0);
      rtc_sec = ts;
      pulse(i, w);
      repeat (14) @(negedge clk);
      exp = accepted(en[i], fl[i], w);
      rd(4'd1, v); chk("R2 random status", v, stat_word(exp ? 1 : 0, 0, 0, 0, exp, 0));
      rd(4'd6, v); chk("R1 random tag", v, exp ? tag_word(i) : 32'd0);
      if (exp) begin
        rd(4'd2, v); chk("R4 random stamp", v, ts);
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule